// File: doc/BRIEF.md
# Strobe-Activity Watchdog

This block watches a strobe line that a processor toggles while its software is healthy. Each transition of the strobe, rising or falling, restarts a fixed countdown. If the countdown runs out before the next transition, the active-low output `wdo_no` drops. It stays low until a transition arrives. The output can drive an interrupt line, or it can feed a reset generator so that a hung processor gets restarted.

The timer has two ways to be switched off. The first is a flag that marks the strobe pin as floating or tri-stated; the analog sensing behind that flag sits outside this block. The second is the system reset. While either one is active, the timer is cleared and idle, and the output stays high. The output also reports supply loss: it is low whenever `supply_ok_i` is false, and there is no minimum pulse width.

The strobe goes through a synchronizer chain and then an edge detector, so pulses as short as one clock period are resolved. The timeout is a parameter counted in clock ticks.

Top module: `wdog_monitor`

## Requirements
- R1: Clock reset is `rst_ni` low, asynchronous. During and after it, `wdo_no` equals `supply_ok_i` and the timer is idle. The synchronizer registers clear to low, so a strobe that is high when reset releases counts as one rising transition.
- R2: A strobe value sampled at clock n is registered as a transition at clock n+SYNC_STAGES. Each registered transition restarts a full countdown. Transitions spaced closer than TIMEOUT_TICKS clocks keep `wdo_no` high.
- R3: If no transition is registered for TIMEOUT_TICKS clocks after the last one, `wdo_no` falls. It falls at the clock edge TIMEOUT_TICKS edges after the edge that registered that transition.
- R4: Once `wdo_no` has fallen on timeout, it stays low until a transition is registered. It rises at the clock that registers the transition.
- R5: Rising and falling strobe transitions restart the countdown in the same way.
- R6: While `strobe_float_i` is high, the timer is cleared and ignores strobe transitions, and `wdo_no` is high if the supply is good. After the flag drops, no countdown starts until the next registered transition.
- R7: While `sys_reset_i` is high, the timer is cleared and ignores strobe transitions, and `wdo_no` is high if the supply is good. After it drops, counting begins only at the first registered transition.
- R8: `wdo_no` goes low in the same cycle that `supply_ok_i` goes low. It goes high again as soon as `supply_ok_i` returns, unless the timer has expired. A supply loss one cycle long produces a low pulse one cycle long.
- R9: A strobe pulse one clock period wide registers both of its transitions.
- R10: The countdown keeps running while the supply is bad. A timeout that occurs during supply loss keeps `wdo_no` low after the supply returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low register reset |
| strobe_i | input | 1 | Activity strobe from the processor |
| strobe_float_i | input | 1 | High when the strobe pin is floating or tri-stated |
| sys_reset_i | input | 1 | System reset, active high; disables and clears the timer |
| supply_ok_i | input | 1 | High while the supply is above its threshold |
| wdo_no | output | 1 | Watchdog output, active low |

## Verification
Two events can fall in the same cycle: a supply loss and a timer expiry. The bench lets the timer run out while `supply_ok_i` is held low. It then restores the supply and expects the output to stay low. It also drops the supply for a single cycle while the timer is healthy and expects an exactly one-cycle low pulse. A behavioural model tracks how long it has been since the last registered strobe transition, and the bench compares the output with that model on every clock, including the cycles where a transition arrives just as the disable inputs change.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Timer phase: idle (not counting), run (counting), trip (expired)
    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUN  = 2'd1,
        WD_TRIP = 2'd2
    } wd_phase_e;

    // Combined disable condition for the timer
    function automatic logic wd_gate_off(input logic sys_rst, input logic floating);
        return sys_rst | floating;
    endfunction

endpackage

// File: rtl/wdog_edge_sync.sv
module wdog_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic strobe_i,
    output logic edge_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.chain[0] = strobe_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.prev     = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Either polarity of change is a transition (R5)
    assign edge_o = s_q.chain[STAGES-1] ^ s_q.prev;

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int TICKS = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic gate_off_i,
    input  logic kick_i,
    output logic trip_o
);

    localparam int              CNT_W = (TICKS > 2) ? $clog2(TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

    typedef struct packed {
        wd_phase_e        phase;
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (gate_off_i) begin
            t_d.phase = WD_IDLE;
            t_d.cnt   = '0;
        end else if (kick_i) begin
            t_d.phase = WD_RUN;
            t_d.cnt   = '0;
        end else if (t_q.phase == WD_RUN) begin
            if (t_q.cnt == LAST) begin
                t_d.phase = WD_TRIP;
            end else begin
                t_d.cnt = t_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            t_q.phase <= WD_IDLE;
            t_q.cnt   <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign trip_o = (t_q.phase == WD_TRIP);

    // R3
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        t_q.cnt <= LAST);

    // R3
    trip_after_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(trip_o) |-> ($past(t_q.cnt) == LAST && $past(t_q.phase) == WD_RUN));

    // R6
    idle_on_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gate_off_i |=> (t_q.phase == WD_IDLE && t_q.cnt == '0));

    // R4
    trip_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trip_o && !kick_i && !gate_off_i) |=> trip_o);

    // R2
    kick_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kick_i && !gate_off_i) |=> (t_q.phase == WD_RUN && t_q.cnt == '0));

endmodule

// File: rtl/wdog_monitor.sv
module wdog_monitor
    import wdog_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int TIMEOUT_TICKS = 16_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic strobe_i,
    input  logic strobe_float_i,
    input  logic sys_reset_i,
    input  logic supply_ok_i,
    output logic wdo_no
);

    logic kick;
    logic gate_off;
    logic trip;

    assign gate_off = wd_gate_off(sys_reset_i, strobe_float_i);

    wdog_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .strobe_i (strobe_i),
        .edge_o   (kick)
    );

    wdog_timer #(
        .TICKS (TIMEOUT_TICKS)
    ) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .gate_off_i (gate_off),
        .kick_i     (kick),
        .trip_o     (trip)
    );

    // Supply loss acts directly, with no minimum width (R8)
    assign wdo_no = supply_ok_i & ~trip;

    // R4
    low_until_kick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trip && !kick && !gate_off) |=> !wdo_no);

    // R7
    high_while_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gate_off && supply_ok_i) |=> (wdo_no || !supply_ok_i));

endmodule

// File: tb/tb_wdog_monitor.sv
module tb_wdog_monitor;

    localparam int SYNC = 2;
    localparam int TMO  = 16;

    logic clk = 1'b0;
    logic rst_ni, strobe, floating, sys_rst, supply;
    logic wdo_no;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string phase_req = "R1";

    wdog_monitor #(.SYNC_STAGES(SYNC), .TIMEOUT_TICKS(TMO)) dut (
        .clk_i(clk), .rst_ni(rst_ni), .strobe_i(strobe),
        .strobe_float_i(floating), .sys_reset_i(sys_rst),
        .supply_ok_i(supply), .wdo_no(wdo_no)
    );

    always #5 clk = ~clk;

    // Behavioural reference: sample history and time since last transition
    bit hist[$];
    int quiet = -1;
    bit m_valid = 0;

    always @(posedge clk) begin
        bit edge_seen;
        if (!rst_ni) begin
            hist = {};
            for (int i = 0; i < SYNC + 2; i++) hist.push_back(1'b0);
            quiet = -1;
            m_valid = 0;
        end else begin
            hist.push_front(strobe);
            void'(hist.pop_back());
            edge_seen = (hist[SYNC] != hist[SYNC+1]);
            if (sys_rst || floating) quiet = -1;
            else if (edge_seen) quiet = 0;
            else if (quiet >= 0 && quiet < 1000000) quiet++;
            m_valid = 1;
        end
    end

    function automatic logic expect_out();
        return supply && !(quiet >= TMO);
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: wdo_no=%b expected %b at t=%0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #3;
        if (rst_ni && m_valid) chk(phase_req, wdo_no, expect_out());
    end

    // Watchdog on the bench itself
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: run hung, got %0d cycles expected under 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic toggle();
        @(negedge clk);
        strobe = ~strobe;
    endtask

    initial begin
        rst_ni = 1'b0; strobe = 1'b0; floating = 1'b0; sys_rst = 1'b0; supply = 1'b1;
        idle(3);
        #1 chk("R1", wdo_no, 1'b1);
        @(negedge clk); rst_ni = 1'b1;

        // R7: no countdown before the first transition after reset
        phase_req = "R7";
        idle(40);
        chk("R7", wdo_no, 1'b1);

        // R2 / R5: regular kicks of both polarities
        phase_req = "R5";
        for (int k = 0; k < 6; k++) begin
            toggle();
            idle(9);
        end
        chk("R2", wdo_no, 1'b1);

        // R3: stop kicking, expect timeout
        phase_req = "R3";
        idle(TMO + SYNC + 4);
        chk("R3", wdo_no, 1'b0);

        // R4: stays low, then one kick recovers
        phase_req = "R4";
        idle(10);
        chk("R4", wdo_no, 1'b0);
        toggle();
        idle(SYNC + 2);
        chk("R4", wdo_no, 1'b1);

        // R9: expire, then a one-cycle pulse
        phase_req = "R9";
        idle(TMO + 6);
        chk("R9", wdo_no, 1'b0);
        @(negedge clk); strobe = 1'b1;
        @(negedge clk); strobe = 1'b0;
        idle(SYNC + 2);
        chk("R9", wdo_no, 1'b1);

        // R6: float disables, transitions ignored
        phase_req = "R6";
        idle(TMO + 6);
        @(negedge clk); floating = 1'b1;
        for (int k = 0; k < 4; k++) begin toggle(); idle(3); end
        idle(TMO + 10);
        chk("R6", wdo_no, 1'b1);
        @(negedge clk); floating = 1'b0;
        idle(TMO + 10);
        chk("R6", wdo_no, 1'b1);

        // R7: system reset clears an expired timer
        phase_req = "R7";
        toggle();
        idle(TMO + 8);
        chk("R7", wdo_no, 1'b0);
        @(negedge clk); sys_rst = 1'b1;
        toggle(); idle(5);
        chk("R7", wdo_no, 1'b1);
        @(negedge clk); sys_rst = 1'b0;
        idle(TMO + 10);
        chk("R7", wdo_no, 1'b1);

        // R8: one-cycle supply dip
        phase_req = "R8";
        toggle();
        idle(4);
        @(negedge clk); supply = 1'b0;
        #1 chk("R8", wdo_no, 1'b0);
        @(negedge clk); supply = 1'b1;
        #1 chk("R8", wdo_no, 1'b1);

        // R10: timer expires while supply is bad
        phase_req = "R10";
        toggle();
        idle(3);
        @(negedge clk); supply = 1'b0;
        idle(TMO + 8);
        @(negedge clk); supply = 1'b1;
        #1 chk("R10", wdo_no, 1'b0);
        idle(3);
        toggle();
        idle(SYNC + 2);
        chk("R10", wdo_no, 1'b1);

        idle(5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule